// File: doc/BRIEF.md
# Image Checksum Insertion Unit

This unit sits in the write path of a configuration image. The image arrives as a stream of beats with a valid/ready handshake and a last flag that marks its final beat. The unit sends every beat on unchanged except the final one. In that final slot it writes a checksum chosen so that the whole image, read back and summed, gives zero. The image length is not fixed. It is set by where the last flag appears.

Two element widths are supported, and the `wide_sel` input picks one per image. When `wide_sel` is 1, each beat is one 32-bit element. Its byte lanes are little-endian, so bits [7:0] are the least significant byte, and the sum wraps modulo 2^32. When `wide_sel` is 0, each beat carries one byte in bits [7:0] and the sum wraps modulo 256.

The controller is a two-state machine. `ST_FIRST` waits for the first element of an image. A transition called *open* (a non-last element is accepted in `ST_FIRST`) moves it to `ST_BODY` and latches the mode. *Continue* (a non-last element is accepted in `ST_BODY`) stays in `ST_BODY`. *Close* (the last element is accepted in `ST_BODY`) returns to `ST_FIRST`. *Single* (the last element is accepted in `ST_FIRST`) stays in `ST_FIRST`. Each accepted element is captured in a one-entry output register and is presented on the next cycle.

Top module: `img_csum_insert`

## Requirements
- R1: The elements of an emitted image, summed at the element width of that image, total zero.
- R2: When `wide_sel` is 1, elements are the full 32-bit beat with byte lanes in little-endian order. The sum wraps modulo 2^32, and the checksum is the bitwise inverse of that sum plus one.
- R3: When `wide_sel` is 0, the element is `in_data[7:0]` and the sum wraps modulo 256. Bits [31:8] of the input are ignored, and bits [31:8] of every output beat are zero.
- R4: The value presented on `in_data` with the last beat has no effect on the output. The checksum replaces it.
- R5: Every element before the last is emitted unchanged, masked to the element width.
- R6: An image of one element emits zero, with `out_last` set.
- R7: `wide_sel` is sampled only with the first element of an image. Changes to it later in the same image are ignored.
- R8: `out_last` is 1 only on the beat that carries the checksum.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output beat holds steady. `in_ready` equals `!out_valid || out_ready`. No element is lost or duplicated.
- R10: When the output register is empty, an element accepted at a clock edge appears on the output after that same edge.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R12: After a last element is accepted, the running sum restarts from zero, so images that follow back to back are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_sel | input | 1 | Mode select: 1 = 32-bit elements, 0 = byte elements; sampled with the first element |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take an input beat |
| in_data | input | DATA_W | Input element |
| in_last | input | 1 | Marks the final element of the image |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | DATA_W | Output element or checksum |
| out_last | output | 1 | Marks the checksum beat |

## Verification
Two things can happen in the same cycle: a new element is accepted, and the held element is handed downstream. The same overlap occurs when the checksum leaves while the first element of the next image enters and the running sum is cleared. The bench sends images back to back while a pseudo-random pattern drives `out_ready`, so these overlaps occur at many different offsets. A scoreboard queue checks each emitted beat in order, and a second, independent sum over the actual output must return to zero at every last beat.

// File: rtl/ckins_pkg.sv
package ckins_pkg;
    typedef enum logic {
        ST_FIRST = 1'b0,
        ST_BODY  = 1'b1
    } ckins_state_e;

    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/ckins_sum.sv
module ckins_sum #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_eff,
    input  logic              first,
    input  logic              take,
    input  logic              last,
    input  logic [DATA_W-1:0] elem_raw,
    output logic [DATA_W-1:0] elem_out,
    output logic [DATA_W-1:0] csum
);
    localparam int unsigned LANES        = DATA_W / ckins_pkg::LANE_W;
    localparam int unsigned NARROW_LANES = NARROW_W / ckins_pkg::LANE_W;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] base;

    // Lanes inside the narrow width are always live; upper lanes only in wide mode.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            if (g < NARROW_LANES) begin : g_keep
                assign lane_mask[g*ckins_pkg::LANE_W +: ckins_pkg::LANE_W] = '1;
            end else begin : g_gate
                assign lane_mask[g*ckins_pkg::LANE_W +: ckins_pkg::LANE_W] = {ckins_pkg::LANE_W{wide_eff}};
            end
        end
    endgenerate

    always_comb begin
        base     = first ? '0 : acc_q;
        elem_out = elem_raw & lane_mask;
        csum     = (~base + DATA_W'(1)) & lane_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= last ? '0 : ((base + elem_out) & lane_mask);
        end
    end

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (take && last) |=> (acc_q == '0)) else $error("sum not cleared"); // R12
    AST_ACC_NARROW: assert property (@(posedge clk) disable iff (!rst_n) (!first && !wide_eff) |-> ((acc_q >> NARROW_W) == '0)) else $error("narrow sum too wide"); // R3
endmodule

// File: rtl/ckins_outreg.sv
module ckins_outreg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_last,
    input  logic              d_wide,
    input  logic              out_ready,
    output logic              space,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_wide
);
    assign space = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_wide  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= d_data;
            out_last  <= d_last;
            out_wide  <= d_wide;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))) else $error("output changed under stall"); // R9
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) load |=> out_valid) else $error("loaded beat not shown"); // R10
endmodule

// File: rtl/img_csum_insert.sv
module img_csum_insert #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    import ckins_pkg::*;

    ckins_state_e      state_q, state_d;
    logic              mode_q;
    logic              wide_eff;
    logic              take;
    logic              is_first;
    logic              space;
    logic              out_wide;
    logic [DATA_W-1:0] elem_out;
    logic [DATA_W-1:0] csum;
    logic [DATA_W-1:0] beat_d;

    // State register and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && state_q == ST_FIRST) begin
                mode_q <= wide_sel;
            end
        end
    end

    // Next state and control outputs.
    always_comb begin
        in_ready = space;
        take     = in_valid && space;
        is_first = (state_q == ST_FIRST);
        wide_eff = is_first ? wide_sel : mode_q;
        state_d  = state_q;
        unique case (state_q)
            ST_FIRST: if (take && !in_last) state_d = ST_BODY;
            ST_BODY:  if (take && in_last)  state_d = ST_FIRST;
            default:  state_d = ST_FIRST;
        endcase
        beat_d = in_last ? csum : elem_out;
    end

    ckins_sum #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_eff (wide_eff),
        .first    (is_first),
        .take     (take),
        .last     (in_last),
        .elem_raw (in_data),
        .elem_out (elem_out),
        .csum     (csum)
    );

    ckins_outreg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .d_data    (beat_d),
        .d_last    (in_last),
        .d_wide    (wide_eff),
        .out_ready (out_ready),
        .space     (space),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_wide  (out_wide)
    );

    AST_IMAGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (take && in_last) |=> (state_q == ST_FIRST)) else $error("image end not seen"); // R12
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_BODY && $past(state_q) == ST_BODY) |-> $stable(mode_q)) else $error("mode moved mid-image"); // R7
    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_wide) |-> ((out_data >> NARROW_W) == '0)) else $error("narrow beat has upper bits"); // R3
    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (take && in_last && state_q == ST_FIRST) |=> (out_valid && out_last && out_data == '0)) else $error("single image checksum nonzero"); // R6
    AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> in_ready) else $error("stalled while empty"); // R9
endmodule

// File: tb/img_csum_insert_bench.sv
module img_csum_insert_bench;
    typedef struct {
        logic [31:0] data;
        logic        last;
        logic        wide;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          bp_en = 1'b0;
    bit          finished = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [31:0] run_sum = '0;
    logic [31:0] img [0:63];
    exp_t        sb[$];

    always #4 clk = ~clk;

    img_csum_insert u_img_csum_insert (
        .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: sets ready, then scores beats that will hand off at the next edge.
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", out_data, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.data, e.tag, out_data, e.data);
                check(out_last == e.last, "R8", {31'b0, out_last}, {31'b0, e.last});
                run_sum = e.wide ? run_sum + out_data : {24'h0, run_sum[7:0] + out_data[7:0]};
                if (e.last) begin
                    check(run_sum == 32'h0, "R1", run_sum, 32'h0);
                    run_sum = '0;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=idle");
            finish_run();
        end
    end

    task automatic fill(input int seed, input bit garbage_last, input int n);
        for (int i = 0; i < 64; i++) begin
            img[i] = (32'h9E37_79B9 * (i + seed)) ^ (32'h0135_7531 << (i % 7));
        end
        if (garbage_last) img[n-1] = 32'hDEAD_BEEF ^ seed;
    endtask

    task automatic put_elem(input logic [31:0] d, input logic l, input logic w);
        bit hs;
        @(negedge clk);
        #2;
        in_valid = 1'b1; in_data = d; in_last = l; wide_sel = w;
        forever begin
            hs = in_ready;
            @(posedge clk);
            if (hs) begin
                #1 in_valid = 1'b0;
                break;
            end
            @(negedge clk);
            #2;
        end
    endtask

    task automatic send_image(input int n, input logic wide, input bit flip, input string tag);
        logic [31:0] s;
        logic [31:0] e;
        s = '0;
        for (int i = 0; i < n - 1; i++) begin
            e = wide ? img[i] : {24'h0, img[i][7:0]};
            s = wide ? s + e : {24'h0, s[7:0] + e[7:0]};
            sb.push_back('{e, 1'b0, wide, "R5"});
        end
        e = wide ? (~s + 32'd1) : {24'h0, ~s[7:0] + 8'd1};
        sb.push_back('{e, 1'b1, wide, tag});
        for (int i = 0; i < n; i++) begin
            put_elem(img[i], (i == n - 1), flip ? (wide ^ i[0]) : wide);
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 2000 && sb.size() != 0; k++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        check(out_valid == 1'b0, "R11", {31'b0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R11", {31'b0, in_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R11", {30'b0, out_valid, in_ready}, 32'h1);

        // R10: latency with no backpressure.
        bp_en = 1'b0;
        fill(3, 1'b0, 2);
        sb.push_back('{img[0], 1'b0, 1'b1, "R5"});
        sb.push_back('{~img[0] + 32'd1, 1'b1, 1'b1, "R2"});
        put_elem(img[0], 1'b0, 1'b1);
        check(out_valid == 1'b1 && out_data == img[0], "R10", out_data, img[0]);
        put_elem(img[1], 1'b1, 1'b1);
        drain();

        fill(11, 1'b0, 5);  send_image(5, 1'b1, 1'b0, "R2");
        fill(12, 1'b0, 6);  send_image(6, 1'b0, 1'b0, "R3");
        fill(13, 1'b1, 1);  send_image(1, 1'b1, 1'b0, "R6");
        fill(14, 1'b1, 1);  send_image(1, 1'b0, 1'b0, "R6");
        fill(15, 1'b1, 4);  send_image(4, 1'b1, 1'b1, "R7");
        fill(16, 1'b1, 5);  send_image(5, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 64; i++) img[i] = 32'hFFFF_FFFF;
        send_image(6, 1'b1, 1'b0, "R2");
        send_image(7, 1'b0, 1'b0, "R3");
        fill(17, 1'b1, 9);  send_image(9, 1'b1, 1'b0, "R4");
        drain();

        // Backpressure with back-to-back images.
        bp_en = 1'b1;
        for (int t = 0; t < 12; t++) begin
            fill(40 + t, 1'b1, 3 + t);
            send_image(3 + t, t[0], t[1] & t[2], (t % 2 == 0) ? "R12" : "R9");
        end
        fill(70, 1'b1, 1);  send_image(1, 1'b1, 1'b0, "R6");
        fill(71, 1'b1, 8);  send_image(8, 1'b0, 1'b0, "R4");
        drain();
        bp_en = 1'b0;
        repeat (4) @(posedge clk);
        check(sb.size() == 0, "R9", sb.size(), 32'h0);
        finish_run();
    end
endmodule